// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block merges three reasons to hold a processor in reset into a single reset signal with a guaranteed minimum length. The reasons are a supply-low flag from an external comparator, a manual reset request that has already been filtered, and a one-cycle strobe from a watchdog that has run out. The supply-low flag is first qualified: it must stay high for a set number of consecutive clock cycles before it counts. This keeps short supply dips from resetting the system.

Reset stays asserted while any qualified reason is present. Once the last reason has gone, reset is held for a further fixed number of cycles and then released. If a new reason appears while that hold is counting, the hold starts over. Two reset outputs of opposite polarity are driven. A freeze output is also driven, so that the watchdog can clear itself and stop counting while reset is asserted. All time spans are parameters given in clock cycles.

Top module: `supsv_rst_seq`

## Requirements
- R1: While `arst_n` is low, `rst_o` is 1. After `arst_n` rises, with no reason present, `rst_o` stays 1 for exactly HOLD_CYC rising edges and then goes to 0.
- R2: A reason sampled at a rising edge makes `rst_o` 1 after that edge. A reason is a qualified supply-low, `mr_n_i` = 0, or `wdx_i` = 1. Reset stays 1 for as long as any reason is sampled.
- R3: `uvlo_i` counts as a reason only once it has been sampled high at QUAL_CYC consecutive edges. Reset therefore rises QUAL_CYC+1 edges after the first high sample. Any run shorter than QUAL_CYC leaves `rst_o` at 0.
- R4: After the last edge at which a reason was sampled, `rst_o` stays 1 for exactly HOLD_CYC more edges and falls at the HOLD_CYC-th of them.
- R5: Manual reset is active low. Holding `mr_n_i` at 0 keeps reset asserted, and releasing it to 1 starts the R4 hold.
- R6: A single-cycle `wdx_i` strobe from idle gives a reset pulse exactly HOLD_CYC cycles long.
- R7: A reason that appears while the hold is counting down reloads the full hold. Release then comes HOLD_CYC edges after that reason's last sample.
- R8: `rst_n_o` is always the inverse of `rst_o`, and `wd_frz_o` equals `rst_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset; puts the block in the asserted state |
| uvlo_i | input | 1 | Synchronous supply-below-threshold flag, active high |
| mr_n_i | input | 1 | Filtered manual reset request, active low |
| wdx_i | input | 1 | Watchdog expiry strobe, one cycle, active high |
| rst_n_o | output | 1 | Reset output, active low |
| rst_o | output | 1 | Reset output, active high |
| wd_frz_o | output | 1 | High while reset is asserted; clears and freezes the watchdog |

## Verification
The bound checker tracks, on every cycle, the number of edges since the last reason and the run length of the raw supply flag. Against these it checks the exact hold window, that a reason leads to assertion, that qualification never fires early, and that the two outputs stay complementary. The bench's scenarios are needed to show the things the checker does not prove. These are that a dip one cycle short of qualification is fully ignored, that a reload during the countdown restarts the hold from its full length, and that a lone watchdog strobe gives a pulse of exactly the hold length. A per-cycle reference model covers the randomly mixed overlaps of all three reasons.

// File: rtl/supsv_pkg.sv
package supsv_pkg;

   // Reasons that can request a reset, sampled each cycle.
   typedef struct packed {
      logic uv;    // qualified supply-low
      logic man;   // manual request (active-high form)
      logic wdg;   // watchdog expiry strobe
   } rst_cause_t;

   function automatic int unsigned cnt_bits(input int unsigned maxval);
      return (maxval < 2) ? 1 : $clog2(maxval + 1);
   endfunction

   function automatic logic any_cause(input rst_cause_t c);
      return c.uv | c.man | c.wdg;
   endfunction

endpackage

// File: rtl/supsv_uv_qual.sv
module supsv_uv_qual #(
   parameter int unsigned QUAL_CYC = 4
) (
   input  logic clk,
   input  logic arst_n,
   input  logic uvlo_i,
   output logic uv_q_o
);
   import supsv_pkg::*;

   generate
      if (QUAL_CYC == 0) begin : g_bypass
         assign uv_q_o = uvlo_i;
      end else begin : g_filter
         localparam int unsigned RW = cnt_bits(QUAL_CYC);
         localparam logic [RW-1:0] RMAX = RW'(QUAL_CYC);

         logic [RW-1:0] run_q;
         logic [RW-1:0] run_nx;
         logic          uv_q;

         always_comb begin
            if (!uvlo_i)          run_nx = '0;
            else if (run_q == RMAX) run_nx = RMAX;
            else                  run_nx = run_q + 1'b1;
         end

         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
               run_q <= '0;
               uv_q  <= 1'b0;
            end else begin
               run_q <= run_nx;
               uv_q  <= (run_nx == RMAX);
            end
         end

         assign uv_q_o = uv_q;
      end
   endgenerate

endmodule

// File: rtl/supsv_hold_timer.sv
module supsv_hold_timer #(
   parameter int unsigned HOLD_CYC = 16
) (
   input  logic clk,
   input  logic arst_n,
   input  logic cause_i,
   output logic active_o
);
   import supsv_pkg::*;

   localparam int unsigned    HW    = cnt_bits(HOLD_CYC);
   localparam logic [HW-1:0]  HLOAD = HW'(HOLD_CYC);

   logic [HW-1:0] left_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)             left_q <= HLOAD;
      else if (cause_i)        left_q <= HLOAD;
      else if (left_q != '0)   left_q <= left_q - 1'b1;
   end

   assign active_o = (left_q != '0);

endmodule

// File: rtl/supsv_rst_seq.sv
module supsv_rst_seq #(
   parameter int unsigned QUAL_CYC = 4,
   parameter int unsigned HOLD_CYC = 16
) (
   input  logic clk,
   input  logic arst_n,
   input  logic uvlo_i,
   input  logic mr_n_i,
   input  logic wdx_i,
   output logic rst_n_o,
   output logic rst_o,
   output logic wd_frz_o
);
   import supsv_pkg::*;

   generate
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("supsv_rst_seq: HOLD_CYC must be at least 1");
      end
   endgenerate

   logic       uv_q;
   logic       act;
   rst_cause_t cause;

   supsv_uv_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
      .clk    (clk),
      .arst_n (arst_n),
      .uvlo_i (uvlo_i),
      .uv_q_o (uv_q)
   );

   always_comb begin
      cause.uv  = uv_q;
      cause.man = ~mr_n_i;
      cause.wdg = wdx_i;
   end

   supsv_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk      (clk),
      .arst_n   (arst_n),
      .cause_i  (any_cause(cause)),
      .active_o (act)
   );

   assign rst_o    = act;
   assign rst_n_o  = ~act;
   assign wd_frz_o = act;

endmodule

// File: rtl/supsv_rst_seq_chk.sv
module supsv_rst_seq_chk #(
   parameter int unsigned QUAL_CYC = 4,
   parameter int unsigned HOLD_CYC = 16
) (
   input logic clk,
   input logic arst_n,
   input logic uvlo_i,
   input logic mr_n_i,
   input logic wdx_i,
   input logic uv_q,
   input logic rst_n_o,
   input logic rst_o,
   input logic wd_frz_o
);
   localparam int unsigned QW = $clog2(HOLD_CYC + 2);
   localparam int unsigned RW = $clog2(QUAL_CYC + 2);

   logic [QW-1:0] quiet_q;
   logic [RW-1:0] raw_q;
   logic          cause;

   assign cause = uv_q | ~mr_n_i | wdx_i;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         quiet_q <= '0;
         raw_q   <= '0;
      end else begin
         if (cause)                         quiet_q <= '0;
         else if (quiet_q != QW'(HOLD_CYC)) quiet_q <= quiet_q + 1'b1;
         if (!uvlo_i)                       raw_q <= '0;
         else if (raw_q != RW'(QUAL_CYC))   raw_q <= raw_q + 1'b1;
      end
   end

   // R8: the two polarities always disagree
   a_r8_polarity: assert property (@(posedge clk) disable iff (!arst_n)
      rst_o != rst_n_o);

   // R2: a sampled reason leads to assertion on the next cycle
   a_r2_cause_asserts: assert property (@(posedge clk) disable iff (!arst_n)
      cause |=> rst_o);

   // R4: asserted throughout the hold window
   a_r4_hold_window: assert property (@(posedge clk) disable iff (!arst_n)
      (quiet_q < QW'(HOLD_CYC)) |-> rst_o);

   // R4: released once the hold window is complete
   a_r4_release: assert property (@(posedge clk) disable iff (!arst_n)
      (quiet_q == QW'(HOLD_CYC)) |-> !rst_o);

   // R3: qualified flag only after enough consecutive raw samples
   a_r3_qual_run: assert property (@(posedge clk) disable iff (!arst_n)
      uv_q |-> (raw_q >= RW'(QUAL_CYC)));

   // R8: freeze follows the reset state
   a_r8_freeze: assert property (@(posedge clk) disable iff (!arst_n)
      wd_frz_o != rst_n_o);

endmodule

bind supsv_rst_seq supsv_rst_seq_chk #(.QUAL_CYC(QUAL_CYC), .HOLD_CYC(HOLD_CYC)) i_chk (
   .clk      (clk),
   .arst_n   (arst_n),
   .uvlo_i   (uvlo_i),
   .mr_n_i   (mr_n_i),
   .wdx_i    (wdx_i),
   .uv_q     (uv_q),
   .rst_n_o  (rst_n_o),
   .rst_o    (rst_o),
   .wd_frz_o (wd_frz_o)
);

// File: tb/test_supsv_rst_seq.sv
module test_supsv_rst_seq;
   localparam int Q = 4;
   localparam int T = 16;

   logic clk = 1'b0;
   logic arst_n = 1'b0;
   logic uvlo_i = 1'b0;
   logic mr_n_i = 1'b1;
   logic wdx_i = 1'b0;
   logic rst_n_o, rst_o, wd_frz_o;

   int n_chk = 0;
   int n_fail = 0;
   int m_run = 0;
   int m_cnt = T;
   bit m_uvq = 1'b0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   supsv_rst_seq #(.QUAL_CYC(Q), .HOLD_CYC(T)) i_supsv_rst_seq (
      .clk(clk), .arst_n(arst_n), .uvlo_i(uvlo_i), .mr_n_i(mr_n_i),
      .wdx_i(wdx_i), .rst_n_o(rst_n_o), .rst_o(rst_o), .wd_frz_o(wd_frz_o)
   );

   function automatic bit exp_rst(input int cnt);
      return cnt != 0;
   endfunction

   task automatic check(input bit act, input bit exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: rst actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_all(input string req);
      bit e;
      e = exp_rst(m_cnt);
      check(rst_o, e, req);
      check(~rst_n_o, e, "R8 low-polarity");
      check(wd_frz_o, e, "R8 freeze");
   endtask

   // drive one cycle: set inputs, advance model over the next edge, check
   task automatic step(input bit u, input bit m, input bit w, input string req);
      bit cause;
      uvlo_i = u; mr_n_i = m; wdx_i = w;
      cause = m_uvq | !m | w;
      m_run = u ? ((m_run < Q) ? m_run + 1 : Q) : 0;
      m_uvq = (m_run >= Q);
      m_cnt = cause ? T : ((m_cnt > 0) ? m_cnt - 1 : 0);
      @(negedge clk);
      check_all(req);
   endtask

   task automatic idle(input int n, input string req);
      for (int i = 0; i < n; i++) step(1'b0, 1'b1, 1'b0, req);
   endtask

   initial begin
      repeat (30000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      // R1: asserted during reset
      repeat (2) @(negedge clk);
      check(rst_o, 1'b1, "R1 during arst");
      check(rst_n_o, 1'b0, "R1 during arst low-polarity");
      arst_n = 1'b1;
      // R1: held exactly T edges after release
      idle(T + 3, "R1 power-on hold");

      // R3: dip one cycle short of qualification is ignored
      for (int i = 0; i < Q - 1; i++) step(1'b1, 1'b1, 1'b0, "R3 short dip");
      idle(4, "R3 short dip ignored");
      check(rst_o, 1'b0, "R3 short dip no reset");
      // R3/R4: qualified dip, then release hold
      for (int i = 0; i < Q + 5; i++) step(1'b1, 1'b1, 1'b0, "R3 qualified dip");
      idle(T + 3, "R4 uv release hold");

      // R6: single watchdog strobe
      step(1'b0, 1'b1, 1'b1, "R6 wd strobe");
      idle(T + 3, "R6 wd pulse length");

      // R5: manual reset held, then release
      for (int i = 0; i < 7; i++) step(1'b0, 1'b0, 1'b0, "R5 manual held");
      idle(T + 3, "R5 manual release");

      // R7: reload in the middle of the countdown
      step(1'b0, 1'b1, 1'b1, "R7 first strobe");
      idle(T / 2, "R7 counting");
      step(1'b0, 1'b0, 1'b0, "R7 reload cause");
      idle(T - 1, "R7 still held after reload");
      check(rst_o, 1'b1, "R7 held until full hold");
      idle(3, "R7 release after reload");

      // R2: random mix of reasons
      begin
         bit u = 1'b0;
         for (int i = 0; i < 4000; i++) begin
            bit m, w;
            if ($urandom_range(9) == 0) u = ~u;
            m = ($urandom_range(60) != 0);
            w = ($urandom_range(80) == 0);
            step(u, m, w, "R2 random mix");
         end
      end
      idle(T + 3, "R4 final release");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule